// File: doc/BRIEF.md
# Bitmask-Steered Two-Source Byte Interleaver

This block rebuilds one parent node's symbol sequence inside a tree-transposed prefix-code decoder. Two child byte sequences, a left source and a right source, are merged into one output sequence. A packed stream of selection bits drives the merge, one bit per output element: a 0 takes the next left byte and a 1 takes the next right byte. Each working cycle emits a group of sixteen output bytes. The per-node element count, and the child sequences themselves, come from elsewhere.

Each source is read through a 16-byte window that starts at a read pointer the block drives, and the selection bits are read through a 16-bit window that starts at the element position the block drives. The lane control is built from two 8-lane halves. Left lanes carry complemented indices, so one addition of the lower half's popcount adjusts the upper half for both sources at once. After the group, the right pointer moves by the popcount of the consumed bits and the left pointer moves by the rest. A pulse on `start` loads the element total and clears the positions. When the total is not a multiple of sixteen, the last group is partial.

Top module: `bmerge_top`

## Requirements
- R1: In output lane j (bits 8j+7..8j of `out_data`), selection bit j of the current group picks the source: 0 gives the next unread left byte and 1 gives the next unread right byte, with bytes from each source taken in order.
- R2: Over a whole merge, the right bytes consumed before element e equal the count of 1 bits among the selection bits of elements 0..e-1, and the left bytes consumed equal e minus that count. This holds across group boundaries.
- R3: After each group, `r_ptr` has advanced by the number of consumed 1 bits and `l_ptr` by the number of consumed elements minus that count. `l_ptr + r_ptr` always equals `sel_pos`.
- R4: The upper eight lanes of a group read correctly for every lower-half popcount from 0 to 8, including lower halves that are all left or all right.
- R5: In a final group with n < 16 remaining elements, `out_mask` has exactly bits 0..n-1 set and the data bytes of the lanes above are zero. Selection bits at lane n and above do not move either pointer.
- R6: A group is consumed only on a cycle where `busy`, `l_ok`, `r_ok` and `sel_ok` are all 1. On any other cycle with `busy` high, the next cycle has `out_valid` low and `out_data` and `out_mask` unchanged.
- R7: `start` loads `total_cnt` and clears `l_ptr`, `r_ptr` and `sel_pos`. `busy` rises only when the total is nonzero, so a zero total produces no output.
- R8: After synchronous reset, `busy`, `out_valid`, `out_mask`, `out_data`, both pointers and `sel_pos` are zero.
- R9: `out_valid` is high for exactly one cycle after each consumed group, so a merge of T elements produces ceil(T/16) valid groups. `busy` falls on the same edge as the last group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new merge |
| total_cnt | input | CNT_W | Number of output elements, sampled on start |
| l_win | input | 128 | Left bytes at l_ptr..l_ptr+15, byte k in bits 8k+7..8k |
| l_ok | input | 1 | Left window holds 16 valid bytes |
| r_win | input | 128 | Right bytes at r_ptr..r_ptr+15 |
| r_ok | input | 1 | Right window holds 16 valid bytes |
| sel_bits | input | 16 | Selection bits for elements sel_pos..sel_pos+15, bit j for lane j |
| sel_ok | input | 1 | Selection window valid |
| l_ptr | output | CNT_W | Left read pointer |
| r_ptr | output | CNT_W | Right read pointer |
| sel_pos | output | CNT_W | Index of the next output element |
| busy | output | 1 | Merge in progress |
| out_data | output | 128 | Merged group, lane j in bits 8j+7..8j |
| out_mask | output | 16 | Valid lanes of out_data |
| out_valid | output | 1 | out_data holds a new group |

## Verification
The sweep drives selection patterns that push the lower-half popcount to both ends and everywhere between. An upper-half offset with the wrong sign, or a missing bias on the left indices, would fetch bytes shifted by a few positions in lanes 8 to 15. Totals just below, at and just above multiples of sixteen test the partial final group, and the selection bits past the total are all ones. A block that counted those ignored bits would leave `r_ptr` too high at the end and would misalign every later byte. Ready signals are dropped in staggered cycles, which catches a block that advances or alters its output while starved. Zero and single-element totals check the start edge cases.

// File: rtl/bmerge_pkg.sv
package bmerge_pkg;

    localparam int LANES  = 16;
    localparam int HALF   = LANES / 2;
    localparam int BYTE_W = 8;
    localparam int VEC_W  = LANES * BYTE_W;
    localparam int LCNT_W = $clog2(LANES + 1);

    typedef logic [BYTE_W-1:0] lane_idx_t;

    typedef enum logic {
        MS_IDLE = 1'b0,
        MS_RUN  = 1'b1
    } mstate_e;

    typedef struct packed {
        logic [LCNT_W-1:0] n_elem;
        logic [LCNT_W-1:0] n_right;
        logic [LANES-1:0]  lane_en;
    } grp_step_t;

    function automatic logic [LCNT_W-1:0] ones16(input logic [LANES-1:0] v);
        logic [LCNT_W-1:0] c;
        c = '0;
        for (int i = 0; i < LANES; i++) c = c + LCNT_W'(v[i]);
        return c;
    endfunction

    function automatic logic [3:0] ones8(input logic [HALF-1:0] v);
        logic [3:0] c;
        c = '0;
        for (int i = 0; i < HALF; i++) c = c + 4'(v[i]);
        return c;
    endfunction

endpackage

// File: rtl/bmerge_half_idx.sv
module bmerge_half_idx
    import bmerge_pkg::*;
#(
    parameter int L_BIAS = 0
) (
    input  logic [HALF-1:0]        bits_in,
    output logic [HALF*BYTE_W-1:0] idx_out
);
    // right lanes: index = ones seen so far; left lanes: 255 - bias - zeros seen so far
    always_comb begin
        int r_seen;
        int l_seen;
        r_seen  = 0;
        l_seen  = 0;
        idx_out = '0;
        for (int j = 0; j < HALF; j++) begin
            if (bits_in[j]) begin
                idx_out[j*BYTE_W +: BYTE_W] = BYTE_W'(r_seen);
                r_seen = r_seen + 1;
            end else begin
                idx_out[j*BYTE_W +: BYTE_W] = BYTE_W'(255 - L_BIAS - l_seen);
                l_seen = l_seen + 1;
            end
        end
    end
endmodule

// File: rtl/bmerge_gather.sv
module bmerge_gather
    import bmerge_pkg::*;
(
    input  logic [VEC_W-1:0] idx_vec,
    input  logic [VEC_W-1:0] l_win,
    input  logic [VEC_W-1:0] r_win,
    output logic [VEC_W-1:0] merged
);
    for (genvar j = 0; j < LANES; j++) begin : g_lane
        lane_idx_t ri;
        lane_idx_t li;
        logic [BYTE_W-1:0] rb;
        logic [BYTE_W-1:0] lb;
        assign ri = idx_vec[j*BYTE_W +: BYTE_W];
        assign li = ~ri;
        assign rb = ri[BYTE_W-1] ? '0 : r_win[ri[3:0]*BYTE_W +: BYTE_W];
        assign lb = li[BYTE_W-1] ? '0 : l_win[li[3:0]*BYTE_W +: BYTE_W];
        assign merged[j*BYTE_W +: BYTE_W] = rb | lb;
    end
endmodule

// File: rtl/bmerge_top.sv
module bmerge_top
    import bmerge_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] total_cnt,
    input  logic [127:0]     l_win,
    input  logic             l_ok,
    input  logic [127:0]     r_win,
    input  logic             r_ok,
    input  logic [15:0]      sel_bits,
    input  logic             sel_ok,
    output logic [CNT_W-1:0] l_ptr,
    output logic [CNT_W-1:0] r_ptr,
    output logic [CNT_W-1:0] sel_pos,
    output logic             busy,
    output logic [127:0]     out_data,
    output logic [15:0]      out_mask,
    output logic             out_valid
);
    mstate_e          state;
    logic [CNT_W-1:0] total_q;
    logic [CNT_W-1:0] remain;
    grp_step_t        stp;
    logic             step;
    logic             last_grp;

    logic [HALF*BYTE_W-1:0] idx_lo;
    logic [HALF*BYTE_W-1:0] idx_hi_raw;
    logic [VEC_W-1:0]       idx_vec;
    logic [VEC_W-1:0]       gathered;
    logic [VEC_W-1:0]       masked;
    logic [3:0]             pop_lo;

    assign busy = (state == MS_RUN);

    bmerge_half_idx #(.L_BIAS(0))    u_lo (.bits_in(sel_bits[HALF-1:0]),     .idx_out(idx_lo));
    bmerge_half_idx #(.L_BIAS(HALF)) u_hi (.bits_in(sel_bits[LANES-1:HALF]), .idx_out(idx_hi_raw));

    assign pop_lo = ones8(sel_bits[HALF-1:0]);

    // upper lanes: one uniform add of the lower popcount fixes both sources
    always_comb begin
        idx_vec[HALF*BYTE_W-1:0] = idx_lo;
        for (int j = 0; j < HALF; j++)
            idx_vec[(HALF+j)*BYTE_W +: BYTE_W] =
                idx_hi_raw[j*BYTE_W +: BYTE_W] + BYTE_W'(pop_lo);
    end

    bmerge_gather u_gather (
        .idx_vec (idx_vec),
        .l_win   (l_win),
        .r_win   (r_win),
        .merged  (gathered)
    );

    assign remain   = total_q - sel_pos;
    assign last_grp = (remain <= CNT_W'(LANES));

    always_comb begin
        stp.n_elem = last_grp ? LCNT_W'(remain) : LCNT_W'(LANES);
        for (int j = 0; j < LANES; j++)
            stp.lane_en[j] = (LCNT_W'(j) < stp.n_elem);
        stp.n_right = ones16(sel_bits & stp.lane_en);
        for (int j = 0; j < LANES; j++)
            masked[j*BYTE_W +: BYTE_W] = stp.lane_en[j] ? gathered[j*BYTE_W +: BYTE_W] : '0;
    end

    assign step = busy && l_ok && r_ok && sel_ok && !start;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= MS_IDLE;
            total_q   <= '0;
            l_ptr     <= '0;
            r_ptr     <= '0;
            sel_pos   <= '0;
            out_data  <= '0;
            out_mask  <= '0;
            out_valid <= 1'b0;
        end else if (start) begin
            state     <= (total_cnt != '0) ? MS_RUN : MS_IDLE;
            total_q   <= total_cnt;
            l_ptr     <= '0;
            r_ptr     <= '0;
            sel_pos   <= '0;
            out_valid <= 1'b0;
        end else if (step) begin
            out_data  <= masked;
            out_mask  <= stp.lane_en;
            out_valid <= 1'b1;
            r_ptr     <= r_ptr + CNT_W'(stp.n_right);
            l_ptr     <= l_ptr + CNT_W'(stp.n_elem - stp.n_right);
            sel_pos   <= sel_pos + CNT_W'(stp.n_elem);
            if (last_grp) state <= MS_IDLE;
        end else begin
            out_valid <= 1'b0;
        end
    end

    // R3
    ptr_sum_chk: assert property (@(posedge clk) disable iff (rst)
        (CNT_W+1)'(l_ptr) + (CNT_W+1)'(r_ptr) == (CNT_W+1)'(sel_pos));

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !start && !(l_ok && r_ok && sel_ok)) |=>
            (!out_valid && $stable(out_data) && $stable(out_mask)));

    // R5
    mask_contig_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_mask[0] && ((out_mask & (out_mask + 16'd1)) == 16'd0)));

    // R9
    valid_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(busy));

    // R7
    pos_bound_chk: assert property (@(posedge clk) disable iff (rst)
        sel_pos <= total_q);

endmodule

// File: tb/bmerge_top_tb_top.sv
`timescale 1ns/1ps
module bmerge_top_tb_top;
    localparam int CW  = 16;
    localparam int MEM = 64;

    logic          clk = 1'b0;
    logic          rst;
    logic          start;
    logic [CW-1:0] total_cnt;
    logic [127:0]  l_win, r_win;
    logic          l_ok, r_ok, sel_ok;
    logic [15:0]   sel_bits;
    logic [CW-1:0] l_ptr, r_ptr, sel_pos;
    logic          busy, out_valid;
    logic [127:0]  out_data;
    logic [15:0]   out_mask;

    logic [7:0] l_mem [MEM];
    logic [7:0] r_mem [MEM];
    logic       sbit  [MEM + 16];
    logic [7:0] exp_b [MEM];

    int checks   = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    bmerge_top #(.CNT_W(CW)) dut_i (
        .clk(clk), .rst(rst), .start(start), .total_cnt(total_cnt),
        .l_win(l_win), .l_ok(l_ok), .r_win(r_win), .r_ok(r_ok),
        .sel_bits(sel_bits), .sel_ok(sel_ok),
        .l_ptr(l_ptr), .r_ptr(r_ptr), .sel_pos(sel_pos), .busy(busy),
        .out_data(out_data), .out_mask(out_mask), .out_valid(out_valid)
    );

    always_comb begin
        for (int k = 0; k < 16; k++) begin
            l_win[k*8 +: 8] = (int'(l_ptr) + k < MEM) ? l_mem[int'(l_ptr) + k] : 8'h00;
            r_win[k*8 +: 8] = (int'(r_ptr) + k < MEM) ? r_mem[int'(r_ptr) + k] : 8'h00;
            sel_bits[k]     = (int'(sel_pos) + k < MEM + 16) ? sbit[int'(sel_pos) + k] : 1'b1;
        end
    end

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // mode 0 all-left, 1 all-right, 2 alternating, 3 lfsr, 4 lower-popcount sweep
    task automatic run(input int mode, input int total, input int seed, input int stall);
        logic [15:0] lf;
        int lp, rp, grp, ngrp, cyc;
        logic pend_step, pend_stall;
        logic [127:0] held_d;
        logic [15:0]  held_m, ev_m;
        logic [127:0] ev_d;
        string tag;
        lf = 16'hACE1 ^ 16'(seed * 40503);
        for (int e = 0; e < MEM + 16; e++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            if (e >= total) sbit[e] = 1'b1;
            else case (mode)
                0: sbit[e] = 1'b0;
                1: sbit[e] = 1'b1;
                2: sbit[e] = 1'((e + seed) % 2);
                3: sbit[e] = lf[0];
                default: sbit[e] = ((e % 16) < 8) ? ((e % 8) < ((e / 16 + seed) % 9))
                                                  : lf[3];
            endcase
        end
        lp = 0; rp = 0;
        for (int e = 0; e < total; e++) begin
            if (sbit[e]) begin exp_b[e] = r_mem[rp]; rp++; end
            else         begin exp_b[e] = l_mem[lp]; lp++; end
        end
        tag = (total % 16 != 0) ? "R5" : ((mode == 4) ? "R4" : "R1");
        @(negedge clk);
        start = 1'b1; total_cnt = CW'(total); l_ok = 1; r_ok = 1; sel_ok = 1;
        @(negedge clk);
        start = 1'b0;
        chk("R7", {l_ptr, r_ptr, sel_pos, 15'd0, busy}, {16'd0, 16'd0, 16'd0, 15'd0, 1'(total != 0)});
        grp = 0; pend_step = 0; pend_stall = 0;
        held_d = out_data; held_m = out_mask;
        ngrp = (total + 15) / 16;
        for (cyc = 0; cyc < 400; cyc++) begin
            if (pend_step) begin
                ev_d = '0; ev_m = '0;
                for (int j = 0; j < 16; j++)
                    if (grp * 16 + j < total) begin
                        ev_m[j] = 1'b1; ev_d[j*8 +: 8] = exp_b[grp * 16 + j];
                    end
                chk("R9", {127'd0, out_valid}, 128'd1);
                chk(tag, out_data, ev_d);
                chk(tag, {112'd0, out_mask}, {112'd0, ev_m});
                grp++;
            end else if (pend_stall) begin
                chk("R6", {out_valid, out_mask, out_data[110:0]}, {1'b0, held_m, held_d[110:0]});
            end
            held_d = out_data; held_m = out_mask;
            if (!busy) break;
            l_ok   = !(stall != 0 && cyc % 3 == 1);
            r_ok   = !(stall != 0 && cyc % 5 == 2);
            sel_ok = !(stall != 0 && cyc % 7 == 4);
            pend_step  = l_ok && r_ok && sel_ok;
            pend_stall = !pend_step;
            @(negedge clk);
        end
        chk("R9", {96'd0, 32'(grp)}, {96'd0, 32'(ngrp)});
        chk("R3", {96'd0, l_ptr, r_ptr}, {96'd0, CW'(lp), CW'(rp)});
        chk("R2", {112'd0, sel_pos}, {112'd0, CW'(total)});
    endtask

    initial begin
        #1_000_000;
        failures++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < MEM; i++) begin
            l_mem[i] = 8'((i * 3 + 1) & 8'h7f);
            r_mem[i] = 8'h80 | 8'(i);
        end
        for (int e = 0; e < MEM + 16; e++) sbit[e] = 1'b0;
        rst = 1'b1; start = 1'b0; total_cnt = '0; l_ok = 1; r_ok = 1; sel_ok = 1;
        repeat (3) @(negedge clk);
        // R8 reset state
        chk("R8", {out_data}, 128'd0);
        chk("R8", {78'd0, busy, out_valid, out_mask, l_ptr, r_ptr}, 128'd0);
        chk("R8", {112'd0, sel_pos}, 128'd0);
        rst = 1'b0;
        run(0, 20, 0, 0);
        run(1, 20, 0, 0);
        run(2, 33, 0, 0);
        run(2, 15, 1, 1);
        run(3, 48, 0, 0);
        run(3, 47, 2, 1);
        run(3, 1, 3, 0);
        run(3, 17, 4, 1);
        run(4, 16, 0, 1);
        run(0, 0, 0, 0);
        chk("R7", {126'd0, busy, out_valid}, 128'd0);
        for (int s = 0; s < 9; s++) run(4, 48 - s, s, s % 2);
        for (int s = 0; s < 12; s++) run(3, 16 + 3 * s, s + 7, s % 2);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule